// File: doc/BRIEF.md
# Switch Processor Access Port

This block connects a host processor to the memories of a time slot interchange switch. The bus is not multiplexed and carries 8 data bits and 6 address bits. An active-low select and an active-high strobe frame each transfer, a read/not-write line gives its direction, and an active-low acknowledge ends it. Only 32 locations are visible through the address lines at one time.

A one-byte control register picks which memory those 32 locations fall in and which of the eight streams they cover. The memories are the received-sample store, the low connection store and the high connection store. A split setting in the same register sends every memory read to the sample store and every memory write to the low connection store.

The serial side of the switch owns most memory cycles. A host request therefore waits for a cycle that the serial side flags as free, and the acknowledge delay varies. Control register transfers are answered at once.

Top module: `tsi_cpu_port`

## Requirements
- R1: After reset the control register reads 0x00, `ack_n` is high, `mem_req` is low, and `split_mode` and `proc_mode` are low.
- R2: The control register is a byte laid out as {split, processor mode, unused, select[1:0], stream[2:0]}, from bit 7 down to bit 0. A write stores every field except bit 5. A read returns the stored fields with bit 5 as 0. Either access raises `ack_n` low one clock after the strobe is first sampled.
- R3: With `addr[5]`=0, only `addr[1:0]`=00 reaches the control register, and `addr[4:2]` are ignored. Any other low address is acknowledged but has no effect: writes change nothing, and reads return 0x00.
- R4: With `addr[5]`=1, a memory access presents `mem_addr` = {stream[2:0], `addr[4:0]`} and `mem_sel` = select. The select codes are 01 for the sample store, 10 for the low connection store and 11 for the high connection store. A write also presents `mem_we`=1 and `mem_wdata` = the bus data.
- R5: `mem_req` is held, with a stable address, until a clock edge at which `slot_free` is high. Read data is captured from `mem_rdata` at that edge, and `ack_n` falls right after it. With `slot_free` held high, the acknowledge comes two clocks after the strobe is sampled.
- R6: When the split bit is 1, memory reads use select 01 and memory writes use select 10, whatever the select field holds.
- R7: A memory write that targets select 01 or 00, and a memory read that targets select 00, raise no `mem_req`. The access is still acknowledged one clock after the strobe, and such a read returns 0x00.
- R8: `ack_n` stays low while `cs_n` is low and `ds` is high. It rises one clock after either is released. No new access starts until then.
- R9: `split_mode` and `proc_mode` output control register bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bus address |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data, valid while `ack_n` is low |
| ack_n | output | 1 | Transfer acknowledge, active low |
| mem_req | output | 1 | Memory request towards the core |
| mem_we | output | 1 | Request is a write |
| mem_sel | output | 2 | Target store code |
| mem_addr | output | 8 | Stream and channel index |
| mem_wdata | output | 8 | Write data towards the store |
| mem_rdata | input | 8 | Store read data |
| slot_free | input | 1 | Core cycle available to the host |
| split_mode | output | 1 | Control register split bit |
| proc_mode | output | 1 | Control register processor-mode bit |

## Verification
Control register transfers and transfers that go nowhere acknowledge at the first clock after the strobe is sampled. A memory transfer acknowledges one clock after the first edge at which `slot_free` is high, so the count is two clocks when the slot is always free. The bench counts clock edges from the strobe to the low `ack_n`, with all sampling on the falling edge, and compares that count with these figures. The request fields and grant counts are logged on the falling edge before each grant edge. They are compared after the acknowledge, and again after release, to show that an access which should be dropped made no request.

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port #(
  parameter int STREAM_W = 3,
  parameter int CHAN_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ds,
  input  logic                       rnw,
  input  logic [5:0]                 addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic                       ack_n,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [1:0]                 mem_sel,
  output logic [STREAM_W+CHAN_W-1:0] mem_addr,
  output logic [7:0]                 mem_wdata,
  input  logic [7:0]                 mem_rdata,
  input  logic                       slot_free,
  output logic                       split_mode,
  output logic                       proc_mode
);
  localparam int AW = STREAM_W + CHAN_W;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_ACK} state_t;
  state_t state;

  logic                split_q, proc_q;
  logic [1:0]          msel_q;
  logic [STREAM_W-1:0] stream_q;
  logic                op_we;
  logic [1:0]          op_sel;
  logic [AW-1:0]       op_addr;
  logic [7:0]          op_wdata;

  wire strobe = !cs_n && ds;
  wire start  = (state == S_IDLE) && strobe;
  wire is_ctl = !addr[5] && (addr[1:0] == 2'b00);
  wire [1:0] tgt = split_q ? (rnw ? 2'b01 : 2'b10) : msel_q;
  wire mem_ok = addr[5] && (rnw ? (tgt != 2'b00) : tgt[1]);
  wire [7:0] ctl_rd = {split_q, proc_q, 1'b0, msel_q, stream_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      split_q  <= 1'b0;
      proc_q   <= 1'b0;
      msel_q   <= 2'b00;
      stream_q <= '0;
      rdata    <= 8'h00;
      op_we    <= 1'b0;
      op_sel   <= 2'b00;
      op_addr  <= '0;
      op_wdata <= 8'h00;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (mem_ok) begin
            state    <= S_MEM;
            op_we    <= !rnw;
            op_sel   <= tgt;
            op_addr  <= {stream_q, addr[CHAN_W-1:0]};
            op_wdata <= wdata;
          end else begin
            state <= S_ACK;
            rdata <= (is_ctl && rnw) ? ctl_rd : 8'h00;
            if (is_ctl && !rnw) begin
              split_q  <= wdata[7];
              proc_q   <= wdata[6];
              msel_q   <= wdata[4:3];
              stream_q <= wdata[STREAM_W-1:0];
            end
          end
        end
        S_MEM: if (slot_free) begin
          state <= S_ACK;
          if (!op_we) rdata <= mem_rdata;
        end
        S_ACK: if (!strobe) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ack_n      = (state != S_ACK);
  assign mem_req    = (state == S_MEM);
  assign mem_we     = op_we;
  assign mem_sel    = op_sel;
  assign mem_addr   = op_addr;
  assign mem_wdata  = op_wdata;
  assign split_mode = split_q;
  assign proc_mode  = proc_q;

  AST_REQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !slot_free |=> mem_req && $stable(mem_addr) && $stable(mem_sel)); // R5
  AST_REQ_NOT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ack_n); // R5
  AST_GRANT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && slot_free |=> !ack_n && !mem_req); // R5
  AST_NO_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_sel[1]); // R7
  AST_SPLIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && split_mode |-> mem_sel == (mem_we ? 2'b10 : 2'b01)); // R6
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && !cs_n && ds |=> !ack_n); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && (cs_n || !ds) |=> ack_n && !mem_req); // R8
endmodule

// File: tb/tb_tsi_cpu_port.sv
module tb_tsi_cpu_port;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ds = 0, rnw = 1;
  logic [5:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, mem_wdata, mem_rdata;
  logic [7:0] mem_addr;
  logic [1:0] mem_sel;
  logic ack_n, mem_req, mem_we, split_mode, proc_mode;
  logic slot_free = 0;

  int n_chk = 0, n_bad = 0;
  int free_mode = 1;
  int gnt_cnt = 0;
  logic [1:0] g_sel; logic [7:0] g_addr, g_wdata; logic g_we;
  logic [7:0] rd; int lat;

  tsi_cpu_port dut (.*);

  always #10 clk = ~clk;
  assign mem_rdata = mem_addr ^ 8'h96;

  initial begin : free_gen
    int cyc;
    cyc = 0;
    forever begin
      @(negedge clk);
      if (mem_req && slot_free) begin
        gnt_cnt++; g_sel = mem_sel; g_addr = mem_addr; g_we = mem_we; g_wdata = mem_wdata;
      end
      cyc++;
      slot_free = (free_mode == 1) || (free_mode == 2 && cyc % 4 == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic r, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; ds = 1; rnw = r; addr = a; wdata = d;
    lat = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!ack_n) break;
    end
    rd = rdata;
    cs_n = 1; ds = 0;
    @(negedge clk);
  endtask

  localparam logic [15:0] CTL_VEC [5] = '{16'hFF_DF, 16'h20_00, 16'h5A_5A, 16'hA5_85, 16'h00_00};

  initial begin
    int g0;
    repeat (3) @(negedge clk);
    chk("R1 ack", ack_n, 1); chk("R1 req", mem_req, 0);
    chk("R1 modes", {split_mode, proc_mode}, 0);
    rst_n = 1;
    xfer(1, 6'h00, 0); chk("R1 ctl reset", rd, 8'h00);

    for (int k = 0; k < 5; k++) begin
      xfer(0, 6'h00, CTL_VEC[k][15:8]); chk("R2 write latency", lat, 1);
      xfer(1, 6'h00, 0); chk("R2 readback", rd, CTL_VEC[k][7:0]); chk("R2 read latency", lat, 1);
    end

    xfer(0, 6'h1C, 8'h4D); xfer(1, 6'h00, 0); chk("R3 upper bits ignored", rd, 8'h4D);
    chk("R9 modes", {split_mode, proc_mode}, 2'b01);
    xfer(0, 6'h06, 8'hFF); chk("R3 dead write acked", lat, 1);
    xfer(1, 6'h00, 0); chk("R3 dead write no effect", rd, 8'h4D);
    xfer(1, 6'h05, 0); chk("R3 dead read", rd, 8'h00);

    xfer(0, 6'h00, 8'h1D);
    g0 = gnt_cnt;
    xfer(0, 6'h27, 8'hA1);
    chk("R4 grant", gnt_cnt - g0, 1); chk("R4 sel", g_sel, 2'b11);
    chk("R4 addr", g_addr, 8'hA7); chk("R4 we", g_we, 1); chk("R4 wdata", g_wdata, 8'hA1);
    chk("R5 latency free", lat, 2);
    xfer(0, 6'h00, 8'h12);
    xfer(1, 6'h3F, 0);
    chk("R4 read sel", g_sel, 2'b10); chk("R4 read addr", g_addr, 8'h5F);
    chk("R5 read data", rd, 8'h5F ^ 8'h96);

    free_mode = 0;
    @(negedge clk);
    cs_n = 0; ds = 1; rnw = 1; addr = 6'h21;
    repeat (6) @(negedge clk);
    chk("R5 waits ack", ack_n, 1); chk("R5 waits req", mem_req, 1);
    free_mode = 1;
    @(negedge clk); @(negedge clk);
    chk("R5 ack after free", ack_n, 0); chk("R5 data", rdata, 8'h41 ^ 8'h96);
    g0 = gnt_cnt;
    repeat (4) @(negedge clk);
    chk("R8 ack held", ack_n, 0); chk("R8 no new access", gnt_cnt - g0, 0);
    ds = 0; @(negedge clk);
    chk("R8 ack released", ack_n, 1);
    cs_n = 1;

    free_mode = 2;
    xfer(1, 6'h2A, 0); chk("R5 sparse read", rd, 8'h4A ^ 8'h96);
    free_mode = 1;

    xfer(0, 6'h00, 8'h99);
    chk("R9 split out", split_mode, 1);
    xfer(1, 6'h23, 0); chk("R6 read sel", g_sel, 2'b01); chk("R6 read addr", g_addr, 8'h23);
    xfer(0, 6'h24, 8'h77); chk("R6 write sel", g_sel, 2'b10); chk("R6 write data", g_wdata, 8'h77);

    xfer(0, 6'h00, 8'h09);
    g0 = gnt_cnt;
    xfer(0, 6'h22, 8'h11); chk("R7 ro write no req", gnt_cnt - g0, 0); chk("R7 ro write acked", lat, 1);
    xfer(0, 6'h00, 8'h01);
    xfer(1, 6'h22, 0); chk("R7 reserved read no req", gnt_cnt - g0, 0); chk("R7 reserved read data", rd, 0);
    xfer(0, 6'h22, 8'h11); chk("R7 reserved write no req", gnt_cnt - g0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule